// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one bus machine cycle on a processor bus where the low address byte and the data byte share the same pins. A requester puts a cycle code, a 16-bit address and write data at the block's inputs and pulses `start`. The block then steps through the T-states of that cycle. In the first T-state it places the address on the bus and pulses the address strobe. In the middle T-states it drives the read or write strobe and either releases the shared byte or drives write data onto it. Three status lines tell the outside world what kind of cycle is running.

A read-type cycle samples the shared byte at the close of T3 and keeps it on `rdata`. Opcode fetch and interrupt acknowledge add a fourth T-state in which the bus is quiet while the core decodes. All other cycle kinds end after T3. A `done` pulse marks the last T-state, and `busy` covers the whole cycle. The bus pins are modelled as a separate output, an output enable and an input, which the chip pad ring joins into a tri-state pin.

Top module: `bus_cycle_seq`

## Requirements
- R1: While a cycle runs, `cyc_stat` equals the latched cycle code {bit2 = I/O space, bit1, bit0}. The codes are 011 opcode fetch, 010 memory read, 001 memory write, 110 I/O read, 101 I/O write and 111 interrupt acknowledge. The code is stable from T1 until the last T-state and reads 000 when idle.
- R2: In T1, `addr_hi` carries address bits 15:8, and `mux_out` carries address bits 7:0 with `mux_oe` = 1. The address is latched when `start` is accepted, so later input changes have no effect on it.
- R3: `addr_strobe` is high for T1 only, which is exactly one clock per cycle, and is the first cycle in which `busy` is high.
- R4: In read-type cycles (code bit1 = 1), `rd_strobe_n` is low in T2 and T3, and `mux_oe` is 0 in those states. `rdata` takes the `mux_in` value present at the end of T3 and keeps it until the next read-type cycle.
- R5: Opcode fetch and interrupt acknowledge last 4 T-states. In T4 both strobes are high, `mux_oe` is 0 and `addr_strobe` is 0.
- R6: Memory read, memory write, I/O read and I/O write last 3 T-states, and `busy` is low in the clock after T3.
- R7: In write cycles (code bits 1:0 = 01), `mux_out` carries the write data with `mux_oe` = 1 in T2 and T3. `wr_strobe_n` is low in T2 only, and `rd_strobe_n` stays high.
- R8: After T3, `mux_oe` is 0 until the next cycle's T1.
- R9: `done` is high for exactly one clock, in the final T-state (T3 or T4).
- R10: `start` has no effect when the code is 000 or 100, or while a cycle is running.
- R11: Synchronous `rst` forces idle from any state: both strobes high, `addr_strobe` 0, `mux_oe` 0, `busy` and `done` 0, `cyc_stat` 000, `rdata` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per T-state |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a cycle (accepted only when idle with a valid code) |
| cyc_code | input | 3 | Cycle code, same encoding as `cyc_stat` |
| addr | input | 16 | Cycle address |
| wdata | input | 8 | Data for write cycles |
| mux_in | input | 8 | Byte arriving from the shared pins |
| addr_hi | output | 8 | Upper address byte |
| mux_out | output | 8 | Byte driven onto the shared pins |
| mux_oe | output | 1 | Drive enable for the shared pins |
| addr_strobe | output | 1 | Address latch pulse, T1 only |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| cyc_stat | output | 3 | Cycle status lines |
| rdata | output | 8 | Byte captured by the last read-type cycle |
| done | output | 1 | Final T-state marker |
| busy | output | 1 | A cycle is in progress |

## Verification
The bench drives `mux_in` with the complement of the expected byte until T3. A design that sampled in T2 therefore returns the inverted value. After `start` is taken, the bench changes the request inputs, so a design that does not latch the request puts the wrong address in T1. Cycles of every code check both the length (3 versus 4 T-states) and the state of every strobe per T-state, which exposes a swapped status code, a write strobe held into T3, or a bus still driven in T4. Directed tests cover invalid codes, a `start` raised in mid-cycle, and a reset during T2. A design that failed any of these would start a stray cycle or leave the bus driven.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   typedef enum logic [2:0] {
      TS_IDLE = 3'd0,
      TS_T1   = 3'd1,
      TS_T2   = 3'd2,
      TS_T3   = 3'd3,
      TS_T4   = 3'd4
   } tstate_e;

   localparam logic [2:0] CODE_FETCH = 3'b011;
   localparam logic [2:0] CODE_MRD   = 3'b010;
   localparam logic [2:0] CODE_MWR   = 3'b001;
   localparam logic [2:0] CODE_IORD  = 3'b110;
   localparam logic [2:0] CODE_IOWR  = 3'b101;
   localparam logic [2:0] CODE_INTA  = 3'b111;

   function automatic logic code_valid(input logic [2:0] c);
      return c[1] | c[0];
   endfunction

   function automatic logic code_is_read(input logic [2:0] c);
      return c[1];
   endfunction

   function automatic logic code_is_write(input logic [2:0] c);
      return ~c[1] & c[0];
   endfunction

   function automatic logic code_is_long(input logic [2:0] c);
      return c[1] & c[0];
   endfunction

endpackage

// File: rtl/bcs_tstate_ctrl.sv
module bcs_tstate_ctrl
   import bcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic [2:0] req_code,
   input  logic       cur_long,
   output tstate_e    state,
   output logic       accept,
   output logic       last
);

   tstate_e state_nx;

   assign accept = (state == TS_IDLE) && start && code_valid(req_code);
   assign last   = ((state == TS_T3) && !cur_long) || (state == TS_T4);

   always_comb begin
      state_nx = state;
      unique case (state)
         TS_IDLE: if (accept) state_nx = TS_T1;
         TS_T1:   state_nx = TS_T2;
         TS_T2:   state_nx = TS_T3;
         TS_T3:   state_nx = cur_long ? TS_T4 : TS_IDLE;
         TS_T4:   state_nx = TS_IDLE;
         default: state_nx = TS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= TS_IDLE;
      else     state <= state_nx;
   end

endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen
   import bcs_pkg::*;
#(
   parameter int  ADDR_W     = 16,
   parameter int  DATA_W     = 8,
   parameter bit  HOLD_UPPER = 1'b1,
   localparam int HI_W       = ADDR_W - DATA_W
) (
   input  tstate_e             state,
   input  logic [2:0]          code,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [HI_W-1:0]     addr_hi,
   output logic [DATA_W-1:0]   mux_out,
   output logic                mux_oe,
   output logic                addr_strobe,
   output logic                rd_strobe_n,
   output logic                wr_strobe_n,
   output logic [2:0]          cyc_stat
);

   logic mid;
   logic rd_c;
   logic wr_c;

   assign mid  = (state == TS_T2) || (state == TS_T3);
   assign rd_c = code_is_read(code);
   assign wr_c = code_is_write(code);

   assign addr_strobe = (state == TS_T1);
   assign rd_strobe_n = !(mid && rd_c);
   assign wr_strobe_n = !((state == TS_T2) && wr_c);
   assign mux_oe      = (state == TS_T1) || (mid && wr_c);
   assign mux_out     = (state == TS_T1) ? addr[DATA_W-1:0]
                      : ((mid && wr_c) ? wdata : '0);
   assign cyc_stat    = (state == TS_IDLE) ? 3'b000 : code;

   generate
      if (HOLD_UPPER) begin : g_hold_upper
         assign addr_hi = addr[ADDR_W-1:DATA_W];
      end else begin : g_zero_upper
         assign addr_hi = ((state == TS_T1) || mid) ? addr[ADDR_W-1:DATA_W] : '0;
      end
   endgenerate

endmodule

// File: rtl/bcs_rd_capture.sv
module bcs_rd_capture
   import bcs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  tstate_e           state,
   input  logic [2:0]        code,
   input  logic [DATA_W-1:0] mux_in,
   output logic [DATA_W-1:0] rdata
);

   always_ff @(posedge clk) begin
      if (rst)                                      rdata <= '0;
      else if (state == TS_T3 && code_is_read(code)) rdata <= mux_in;
   end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import bcs_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter bit HOLD_UPPER = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic [2:0]               cyc_code,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [DATA_W-1:0]        mux_in,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic [DATA_W-1:0]        mux_out,
   output logic                     mux_oe,
   output logic                     addr_strobe,
   output logic                     rd_strobe_n,
   output logic                     wr_strobe_n,
   output logic [2:0]               cyc_stat,
   output logic [DATA_W-1:0]        rdata,
   output logic                     done,
   output logic                     busy
);

   localparam int HI_W = ADDR_W - DATA_W;

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("bus_cycle_seq: DATA_W must be at least 1");
      end
      if (HI_W < 1) begin : g_bad_addr_w
         $error("bus_cycle_seq: ADDR_W must exceed DATA_W");
      end
   endgenerate

   tstate_e             state;
   logic                accept;
   logic                last;
   logic [2:0]          code_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q  <= 3'b000;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         code_q  <= cyc_code;
         addr_q  <= addr;
         wdata_q <= wdata;
      end
   end

   bcs_tstate_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .req_code (cyc_code),
      .cur_long (code_is_long(code_q)),
      .state    (state),
      .accept   (accept),
      .last     (last)
   );

   bcs_strobe_gen #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .HOLD_UPPER (HOLD_UPPER)
   ) u_strobe (
      .state       (state),
      .code        (code_q),
      .addr        (addr_q),
      .wdata       (wdata_q),
      .addr_hi     (addr_hi),
      .mux_out     (mux_out),
      .mux_oe      (mux_oe),
      .addr_strobe (addr_strobe),
      .rd_strobe_n (rd_strobe_n),
      .wr_strobe_n (wr_strobe_n),
      .cyc_stat    (cyc_stat)
   );

   bcs_rd_capture #(
      .DATA_W (DATA_W)
   ) u_cap (
      .clk    (clk),
      .rst    (rst),
      .state  (state),
      .code   (code_q),
      .mux_in (mux_in),
      .rdata  (rdata)
   );

   assign done = last;
   assign busy = (state != TS_IDLE);

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
   input logic       clk,
   input logic       rst,
   input logic       mux_oe,
   input logic       addr_strobe,
   input logic       rd_strobe_n,
   input logic       wr_strobe_n,
   input logic [2:0] cyc_stat,
   input logic       done,
   input logic       busy
);

   p_stat_valid_r1: assert property (@(posedge clk) disable iff (rst)
      busy |-> (cyc_stat[1] | cyc_stat[0]));

   p_stat_stable_r1: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy) && !$past(done)) |-> $stable(cyc_stat));

   p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      addr_strobe |=> !addr_strobe);

   p_strobe_first_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> addr_strobe);

   p_rd_bus_free_r4: assert property (@(posedge clk) disable iff (rst)
      !rd_strobe_n |-> !mux_oe);

   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
      !(!rd_strobe_n && !wr_strobe_n));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   p_done_ends_r9: assert property (@(posedge clk) disable iff (rst)
      done |=> !busy);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (rd_strobe_n && wr_strobe_n && !mux_oe && !addr_strobe));

endmodule

bind bus_cycle_seq bcs_checker u_bcs_checker (
   .clk         (clk),
   .rst         (rst),
   .mux_oe      (mux_oe),
   .addr_strobe (addr_strobe),
   .rd_strobe_n (rd_strobe_n),
   .wr_strobe_n (wr_strobe_n),
   .cyc_stat    (cyc_stat),
   .done        (done),
   .busy        (busy)
);

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [2:0]  cyc_code = 3'b000;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  mux_in = '0;
   logic [7:0]  addr_hi;
   logic [7:0]  mux_out;
   logic        mux_oe;
   logic        addr_strobe;
   logic        rd_strobe_n;
   logic        wr_strobe_n;
   logic [2:0]  cyc_stat;
   logic [7:0]  rdata;
   logic        done;
   logic        busy;

   int n_chk  = 0;
   int n_fail = 0;
   logic [7:0] last_rb = 8'h00;

   always #10 clk = ~clk;

   bus_cycle_seq dut (
      .clk(clk), .rst(rst), .start(start), .cyc_code(cyc_code), .addr(addr),
      .wdata(wdata), .mux_in(mux_in), .addr_hi(addr_hi), .mux_out(mux_out),
      .mux_oe(mux_oe), .addr_strobe(addr_strobe), .rd_strobe_n(rd_strobe_n),
      .wr_strobe_n(wr_strobe_n), .cyc_stat(cyc_stat), .rdata(rdata),
      .done(done), .busy(busy)
   );

   // {code, addr, write data, read byte}
   localparam int NV = 10;
   localparam logic [34:0] VEC [NV] = '{
      {3'b011, 16'h5000, 8'h00, 8'h3E},
      {3'b010, 16'h5001, 8'h00, 8'h32},
      {3'b001, 16'hA5C3, 8'h5A, 8'hFF},
      {3'b110, 16'h00F7, 8'h00, 8'hC9},
      {3'b101, 16'h0042, 8'h81, 8'h00},
      {3'b111, 16'hFFFF, 8'h00, 8'hC7},
      {3'b010, 16'h1234, 8'h00, 8'h00},
      {3'b001, 16'hFE01, 8'hA0, 8'h77},
      {3'b011, 16'h8001, 8'h00, 8'hFF},
      {3'b110, 16'h7F80, 8'h00, 8'h01}
   };

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      chk(req, "busy", 16'(busy), 16'd0);
      chk(req, "mux_oe", 16'(mux_oe), 16'd0);
      chk(req, "addr_strobe", 16'(addr_strobe), 16'd0);
      chk(req, "rd_strobe_n", 16'(rd_strobe_n), 16'd1);
      chk(req, "wr_strobe_n", 16'(wr_strobe_n), 16'd1);
      chk(req, "cyc_stat", 16'(cyc_stat), 16'd0);
      chk(req, "done", 16'(done), 16'd0);
   endtask

   // poke: raise start with another request during T2 (R10)
   task automatic run_cycle(input logic [2:0] c, input logic [15:0] a,
                            input logic [7:0] wd, input logic [7:0] rb,
                            input bit poke);
      bit rd   = c[1];
      bit wr   = !c[1] && c[0];
      bit lng  = c[1] && c[0];
      @(negedge clk);
      start = 1'b1; cyc_code = c; addr = a; wdata = wd; mux_in = ~rb;
      @(negedge clk);                                   // T1
      start = 1'b0; addr = ~a; wdata = ~wd; cyc_code = 3'b000;
      chk("R3", "T1 addr_strobe", 16'(addr_strobe), 16'd1);
      chk("R2", "T1 addr_hi", 16'(addr_hi), 16'(a[15:8]));
      chk("R2", "T1 mux_out", 16'(mux_out), 16'(a[7:0]));
      chk("R2", "T1 mux_oe", 16'(mux_oe), 16'd1);
      chk("R1", "T1 cyc_stat", 16'(cyc_stat), 16'(c));
      chk("R4", "T1 rd_strobe_n", 16'(rd_strobe_n), 16'd1);
      chk("R7", "T1 wr_strobe_n", 16'(wr_strobe_n), 16'd1);
      chk("R9", "T1 done", 16'(done), 16'd0);
      if (poke) begin start = 1'b1; cyc_code = 3'b010; end
      @(negedge clk);                                   // T2
      start = 1'b0;
      chk("R3", "T2 addr_strobe", 16'(addr_strobe), 16'd0);
      chk("R1", "T2 cyc_stat", 16'(cyc_stat), 16'(c));
      chk("R2", "T2 addr_hi", 16'(addr_hi), 16'(a[15:8]));
      chk("R4", "T2 rd_strobe_n", 16'(rd_strobe_n), 16'(!rd));
      chk("R7", "T2 wr_strobe_n", 16'(wr_strobe_n), 16'(!wr));
      chk("R4", "T2 mux_oe", 16'(mux_oe), 16'(wr));
      if (wr) chk("R7", "T2 mux_out", 16'(mux_out), 16'(wd));
      @(negedge clk);                                   // T3
      mux_in = rb;
      chk("R4", "T3 rd_strobe_n", 16'(rd_strobe_n), 16'(!rd));
      chk("R7", "T3 wr_strobe_n", 16'(wr_strobe_n), 16'd1);
      chk("R7", "T3 mux_oe", 16'(mux_oe), 16'(wr));
      if (wr) chk("R7", "T3 mux_out", 16'(mux_out), 16'(wd));
      chk("R1", "T3 cyc_stat", 16'(cyc_stat), 16'(c));
      chk("R9", "T3 done", 16'(done), 16'(!lng));
      @(negedge clk);
      mux_in = ~rb;
      if (rd) last_rb = rb;
      chk("R4", "rdata", 16'(rdata), 16'(last_rb));
      chk("R8", "post-T3 mux_oe", 16'(mux_oe), 16'd0);
      if (lng) begin                                    // T4
         chk("R5", "T4 busy", 16'(busy), 16'd1);
         chk("R5", "T4 rd_strobe_n", 16'(rd_strobe_n), 16'd1);
         chk("R5", "T4 wr_strobe_n", 16'(wr_strobe_n), 16'd1);
         chk("R5", "T4 addr_strobe", 16'(addr_strobe), 16'd0);
         chk("R1", "T4 cyc_stat", 16'(cyc_stat), 16'(c));
         chk("R9", "T4 done", 16'(done), 16'd1);
         @(negedge clk);
         chk("R5", "after T4 busy", 16'(busy), 16'd0);
      end else begin
         chk("R6", "after T3 busy", 16'(busy), 16'd0);
      end
      check_idle(poke ? "R10" : "R6");
      chk("R4", "rdata held", 16'(rdata), 16'(last_rb));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R11 reset state
      check_idle("R11");
      chk("R11", "rdata", 16'(rdata), 16'd0);

      for (int i = 0; i < NV; i++) begin
         run_cycle(VEC[i][34:32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0], 1'b0);
      end

      // R10: invalid codes are ignored
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         start = 1'b1; cyc_code = (k == 0) ? 3'b000 : 3'b100; addr = 16'h1111;
         @(negedge clk);
         start = 1'b0;
         check_idle("R10");
         @(negedge clk);
         check_idle("R10");
      end

      // R10: start during a running cycle is ignored
      run_cycle(3'b001, 16'h2468, 8'h3C, 8'h00, 1'b1);
      run_cycle(3'b111, 16'h0038, 8'h00, 8'hE7, 1'b1);

      // R11: reset in mid-cycle
      @(negedge clk);
      start = 1'b1; cyc_code = 3'b010; addr = 16'h4321; mux_in = 8'h99;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);                                   // T2
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check_idle("R11");
      chk("R11", "rdata after reset", 16'(rdata), 16'd0);
      last_rb = 8'h00;
      @(negedge clk);
      check_idle("R11");

      // back to normal operation after reset
      run_cycle(3'b010, 16'hBEEF, 8'h00, 8'h5D, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule